// File: doc/BRIEF.md
# Key Event Queue with Offset Peek

This block holds keypad events in a 16-slot circular store. Each arriving event has a 7-bit key code and a flag that tells a press from a release. It is written behind the newest stored entry. A command front end reads the store in two ways. A consuming read advances the store and returns one entry. A peek returns the entry at a given byte offset and leaves the store as it was. Each accepted event sends a one-cycle pulse toward the status register. Each event refused because the store is full sends a one-cycle pulse toward the error register.

The read pointer names the slot that was consumed last. A consuming read therefore moves the pointer first and then returns the slot it now names. It returns zero while one entry or none is held. Peek offset zero returns the slot under the pointer. When the surrounding status logic reports both its error-summary bit and its overflow-error bit, all incoming events are dropped without effect. This lasts until software clears either bit. A flush pulse empties the store.

Top module: `keyevt_fifo`

## Requirements
- R1: A stored entry holds the key code in bits 6:0 and the press flag in bit 7 (1 = pressed, 0 = released). Reads return it in that layout.
- R2: An accepted event is written at slot (start + count) mod 16 and count then rises by one. `kp_set` pulses high for one cycle, in the cycle after the event.
- R3: An event that arrives when count is 16 is dropped. The stored contents and the count stay unchanged, and `ovf_set` pulses high for one cycle, in the cycle after the event.
- R4: While `stat_err` and `err_ovf` are both 1, events are ignored. Nothing is written and neither pulse is raised. If either input is 0, events are handled normally.
- R5: A consuming read (`pop`) while count is 0 or 1 returns 0x00 and changes no state.
- R6: A consuming read while count is at least 2 advances start by one (mod 16) and lowers count by one. It returns the entry at the new start. `rd_valid` and `rd_data` show the result in the cycle after the request.
- R7: A peek (`peek`) at offset b returns 0x00 when b is at least count. Otherwise it returns the entry at slot (start + b) mod 16. A peek changes no state.
- R8: `flush` sets start and count to zero and drops any event in the same cycle. A read requested in a flush cycle returns 0x00 with `rd_valid` high.
- R9: When an event and a consuming read arrive in the same cycle, the read is done first and the write second. A full store that is read in the same cycle accepts the event.
- R10: When `pop` and `peek` are both high, the consuming read is done and the peek is ignored.
- R11: After reset the store is empty with start at zero. `rd_valid`, `rd_data`, `kp_set` and `ovf_set` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| evt_valid | input | 1 | A key event is presented this cycle |
| evt_code | input | 7 | Key code of the event |
| evt_pressed | input | 1 | 1 = press, 0 = release |
| stat_err | input | 1 | Error-summary bit from the status register |
| err_ovf | input | 1 | Overflow bit from the error register |
| flush | input | 1 | Empty the store |
| pop | input | 1 | Consuming read request |
| peek | input | 1 | Non-consuming read request |
| peek_ofs | input | 8 | Byte offset for a peek |
| rd_valid | output | 1 | Read result present, one cycle after a request |
| rd_data | output | 8 | Read result |
| kp_set | output | 1 | Pulse: an event was stored |
| ovf_set | output | 1 | Pulse: an event was dropped because the store was full |

## Verification
A stimulus table drives these cases:
- Single events, then consuming reads at counts 0, 1 and 2. This exposes an off-by-one in the "advance then read" order.
- Peeks at offsets below count, at count and beyond. These separate a correct bound from one that is loose by a slot.
- An event and a pop in the same cycle, at counts 1, 2 and full. These show whether the read is applied before the write.
- A pop and a peek in the same cycle, at a point where the two would return different values. This shows which read wins.

Directed runs then cover the rest:
- Filling to 16 and overflowing, with peeks that prove the contents are untouched.
- Freezing with both error inputs and then with only one, which shows that both are needed.
- Wrapping the write slot past index 15, and a flush that coincides with reads and events.

// File: rtl/keyevt_pkg.sv
package keyevt_pkg;

  // Which read, if any, is served in a cycle
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_POP  = 2'd1,
    RD_PEEK = 2'd2
  } rd_kind_e;

endpackage

// File: rtl/keyevt_rst_sync.sv
module keyevt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= {sr_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/keyevt_ram.sv
module keyevt_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  // One enabled register per slot; no reset on storage
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == ADDR_W'(g))) begin
        slot_q[g] <= wdata;
      end
    end
  end

  assign rdata = slot_q[raddr];

endmodule

// File: rtl/keyevt_ctrl.sv
module keyevt_ctrl
  import keyevt_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid_i,
  input  logic [DATA_W-1:0] evt_entry_i,
  input  logic              stat_err_i,
  input  logic              err_ovf_i,
  input  logic              flush_i,
  input  logic              pop_i,
  input  logic              peek_i,
  input  logic [OFS_W-1:0]  peek_ofs_i,
  output logic              we_o,
  output logic [PTR_W-1:0]  waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [PTR_W-1:0]  raddr_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              kp_set_o,
  output logic              ovf_set_o
);

  localparam int CMP_W = (OFS_W > CNT_W) ? OFS_W : CNT_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0]  start_q, start_d, start_mid;
  logic [CNT_W-1:0]  len_q, len_d, len_mid;
  logic              frozen, pop_ok, accept, drop, rd_hit, ptr_en;
  rd_kind_e          kind;
  logic              rd_valid_d, kp_d, ovf_d;
  logic [DATA_W-1:0] rd_data_d;

  // Next-state: read first, then write
  always_comb begin
    frozen    = stat_err_i && err_ovf_i;
    pop_ok    = pop_i && (len_q > CNT_W'(1));
    start_mid = pop_ok ? start_q + PTR_W'(1) : start_q;
    len_mid   = pop_ok ? len_q - CNT_W'(1) : len_q;
    accept    = evt_valid_i && !frozen && (len_mid < FULL) && !flush_i;
    drop      = evt_valid_i && !frozen && (len_mid == FULL) && !flush_i;

    waddr_o   = start_mid + len_mid[PTR_W-1:0];
    wdata_o   = evt_entry_i;
    we_o      = accept;

    if (flush_i) begin
      start_d = '0;
      len_d   = '0;
    end else begin
      start_d = start_mid;
      len_d   = accept ? len_mid + CNT_W'(1) : len_mid;
    end
    ptr_en = flush_i || pop_ok || accept;

    if (pop_i)       kind = RD_POP;
    else if (peek_i) kind = RD_PEEK;
    else             kind = RD_NONE;

    case (kind)
      RD_POP: begin
        raddr_o = start_q + PTR_W'(1);
        rd_hit  = pop_ok;
      end
      RD_PEEK: begin
        raddr_o = start_q + peek_ofs_i[PTR_W-1:0];
        rd_hit  = CMP_W'(peek_ofs_i) < CMP_W'(len_q);
      end
      default: begin
        raddr_o = start_q;
        rd_hit  = 1'b0;
      end
    endcase

    rd_valid_d = (kind != RD_NONE);
    rd_data_d  = (rd_hit && !flush_i) ? rdata_i : '0;
    kp_d       = accept;
    ovf_d      = drop;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= '0;
      len_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      kp_set_o   <= 1'b0;
      ovf_set_o  <= 1'b0;
    end else begin
      if (ptr_en) begin
        start_q <= start_d;
        len_q   <= len_d;
      end
      rd_valid_o <= rd_valid_d;
      rd_data_o  <= rd_data_d;
      kp_set_o   <= kp_d;
      ovf_set_o  <= ovf_d;
    end
  end

  // Checks
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= FULL); // R3

  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set_o |-> ($past(len_q) == FULL)); // R3

  AST_FROZEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_err_i && err_ovf_i) |-> !we_o); // R4

  AST_SHORT_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && (len_q <= CNT_W'(1)) && !flush_i) |=> (rd_data_o == '0)); // R5

  AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_i && !pop_i && !evt_valid_i && !flush_i) |=> ($stable(start_q) && $stable(len_q))); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> ((len_q == '0) && (start_q == '0))); // R8

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(kp_set_o && ovf_set_o)); // R2

endmodule

// File: rtl/keyevt_fifo.sv
module keyevt_fifo #(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 7,
  parameter int OFS_W  = 8,
  localparam int DATA_W = CODE_W + 1,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              evt_pressed,
  input  logic              stat_err,
  input  logic              err_ovf,
  input  logic              flush,
  input  logic              pop,
  input  logic              peek,
  input  logic [OFS_W-1:0]  peek_ofs,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              kp_set,
  output logic              ovf_set
);

  logic              rst_sync_n;
  logic              we;
  logic [PTR_W-1:0]  waddr, raddr;
  logic [DATA_W-1:0] wdata, rdata;

  keyevt_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  keyevt_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  keyevt_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OFS_W(OFS_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .evt_valid_i (evt_valid),
    .evt_entry_i ({evt_pressed, evt_code}),
    .stat_err_i  (stat_err),
    .err_ovf_i   (err_ovf),
    .flush_i     (flush),
    .pop_i       (pop),
    .peek_i      (peek),
    .peek_ofs_i  (peek_ofs),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata),
    .raddr_o     (raddr),
    .rdata_i     (rdata),
    .rd_valid_o  (rd_valid),
    .rd_data_o   (rd_data),
    .kp_set_o    (kp_set),
    .ovf_set_o   (ovf_set)
  );

endmodule

// File: tb/test_keyevt_fifo.sv
module test_keyevt_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_valid, evt_pressed, stat_err, err_ovf, flush, pop, peek;
  logic [6:0] evt_code;
  logic [7:0] peek_ofs;
  logic       rd_valid, kp_set, ovf_set;
  logic [7:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyevt_fifo i_keyevt_fifo (
    .clk (clk), .rst_n (rst_n),
    .evt_valid (evt_valid), .evt_code (evt_code), .evt_pressed (evt_pressed),
    .stat_err (stat_err), .err_ovf (err_ovf), .flush (flush),
    .pop (pop), .peek (peek), .peek_ofs (peek_ofs),
    .rd_valid (rd_valid), .rd_data (rd_data), .kp_set (kp_set), .ovf_set (ovf_set)
  );

  typedef struct packed {
    logic       evt;
    logic [6:0] code;
    logic       prs;
    logic       pop;
    logic       peek;
    logic [7:0] ofs;
    logic       fl;
    logic       ev;
    logic [7:0] ed;
    logic       ekp;
    logic       eov;
  } vec_t;

  localparam int NV = 17;
  // evt code prs pop peek ofs fl | exp valid data kp ovf
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'h11, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R2 slot0
    '{1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}, // R5 count 1
    '{1'b1, 7'h22, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R1 pressed
    '{1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0}, // R7 ofs0
    '{1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, 1'b1, 8'hA2, 1'b0, 1'b0}, // R1 R7 ofs1
    '{1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 8'd2, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}, // R7 ofs=count
    '{1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 8'hA2, 1'b0, 1'b0}, // R6 advance
    '{1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}, // R5 again
    '{1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b1, 8'hA2, 1'b0, 1'b0}, // R5 R7 no move
    '{1'b1, 7'h05, 1'b1, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0}, // R9 count 1
    '{1'b1, 7'h33, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 1'b1, 8'h85, 1'b1, 1'b0}, // R9 count 2
    '{1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, 1'b1, 8'h33, 1'b0, 1'b0}, // R9 write slot
    '{1'b0, 7'h00, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0, 1'b1, 8'h33, 1'b0, 1'b0}, // R10 pop wins
    '{1'b1, 7'h44, 1'b0, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R8 flush+evt
    '{1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}, // R8 empty
    '{1'b1, 7'h7F, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R1 R2
    '{1'b0, 7'h00, 1'b0, 1'b0, 1'b1, 8'd0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0}  // R1 R8 slot0
  };

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic e, input logic [6:0] c, input logic p,
                       input logic po, input logic pk, input logic [7:0] o,
                       input logic fl);
    evt_valid = e; evt_code = c; evt_pressed = p;
    pop = po; peek = pk; peek_ofs = o; flush = fl;
    @(posedge clk);
    @(negedge clk);
    evt_valid = 1'b0; pop = 1'b0; peek = 1'b0; flush = 1'b0;
  endtask

  task automatic peek_chk(input logic [7:0] o, input logic [7:0] exp, input string req);
    apply(1'b0, 7'h00, 1'b0, 1'b0, 1'b1, o, 1'b0);
    chk(req, "peek valid", {7'd0, rd_valid}, 8'd1);
    chk(req, "peek data", rd_data, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    evt_valid = 1'b0; evt_code = '0; evt_pressed = 1'b0;
    stat_err = 1'b0; err_ovf = 1'b0; flush = 1'b0;
    pop = 1'b0; peek = 1'b0; peek_ofs = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11", "rd_valid", {7'd0, rd_valid}, 8'd0);
    chk("R11", "rd_data", rd_data, 8'h00);
    chk("R11", "kp_set", {7'd0, kp_set}, 8'd0);
    chk("R11", "ovf_set", {7'd0, ovf_set}, 8'd0);
    peek_chk(8'd0, 8'h00, "R11");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].evt, VECS[i].code, VECS[i].prs, VECS[i].pop,
            VECS[i].peek, VECS[i].ofs, VECS[i].fl);
      chk($sformatf("vec%0d", i), "rd_valid", {7'd0, rd_valid}, {7'd0, VECS[i].ev});
      chk($sformatf("vec%0d", i), "rd_data", rd_data, VECS[i].ed);
      chk($sformatf("vec%0d", i), "kp_set", {7'd0, kp_set}, {7'd0, VECS[i].ekp});
      chk($sformatf("vec%0d", i), "ovf_set", {7'd0, ovf_set}, {7'd0, VECS[i].eov});
    end

    // Fill to 16 from empty (R2)
    apply(1'b0, 7'h00, 1'b0, 1'b0, 1'b0, 8'd0, 1'b1);
    for (int i = 0; i < 16; i++) begin
      apply(1'b1, 7'(8'h40 + i), 1'b0, 1'b0, 1'b0, 8'd0, 1'b0);
      chk("R2", "fill kp", {7'd0, kp_set}, 8'd1);
      chk("R2", "fill ovf", {7'd0, ovf_set}, 8'd0);
    end

    // R3 overflow drop
    apply(1'b1, 7'h01, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0);
    chk("R3", "ovf pulse", {7'd0, ovf_set}, 8'd1);
    chk("R3", "no kp", {7'd0, kp_set}, 8'd0);
    @(negedge clk);
    chk("R3", "ovf one cycle", {7'd0, ovf_set}, 8'd0);
    peek_chk(8'd15, 8'h4F, "R3");
    peek_chk(8'd16, 8'h00, "R3");
    peek_chk(8'd0, 8'h40, "R3");

    // R4 freeze with both bits
    stat_err = 1'b1; err_ovf = 1'b1;
    apply(1'b1, 7'h02, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0);
    chk("R4", "frozen ovf", {7'd0, ovf_set}, 8'd0);
    chk("R4", "frozen kp", {7'd0, kp_set}, 8'd0);
    apply(1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0);
    chk("R6", "pop full", rd_data, 8'h41);
    apply(1'b1, 7'h03, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0);
    chk("R4", "frozen kp after pop", {7'd0, kp_set}, 8'd0);
    peek_chk(8'd14, 8'h4F, "R4");
    peek_chk(8'd15, 8'h00, "R4");

    // One bit only: not frozen; write slot wraps to 0 (R2)
    err_ovf = 1'b0;
    apply(1'b1, 7'h12, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0);
    chk("R4", "one bit accepts", {7'd0, kp_set}, 8'd1);
    peek_chk(8'd15, 8'h12, "R2");
    stat_err = 1'b0;

    // R9 full store read and written in same cycle
    apply(1'b1, 7'h13, 1'b0, 1'b1, 1'b0, 8'd0, 1'b0);
    chk("R9", "pop data", rd_data, 8'h42);
    chk("R9", "kp", {7'd0, kp_set}, 8'd1);
    chk("R9", "ovf", {7'd0, ovf_set}, 8'd0);
    peek_chk(8'd15, 8'h13, "R9");
    peek_chk(8'd0, 8'h42, "R9");

    // R8 flush together with pop
    apply(1'b0, 7'h00, 1'b0, 1'b1, 1'b0, 8'd0, 1'b1);
    chk("R8", "flush pop valid", {7'd0, rd_valid}, 8'd1);
    chk("R8", "flush pop data", rd_data, 8'h00);
    peek_chk(8'd0, 8'h00, "R8");

    finish_run();
  end

endmodule